// File: doc/BRIEF.md
# Serial Flash Chip-Erase Sequencer

This block sits on the controller side of an SPI link to a serial NOR flash and performs one full-chip erase per request. A single-cycle `start` pulse launches a fixed series of transactions. The first enables writes. The second reads the status byte to confirm that the write-enable latch took. The third issues the chip-erase opcode. The fourth is a status read that stays open and polls the busy flag. The block finishes with a one-cycle `done` pulse, and `err` reports the outcome.

The pins run in SPI mode 0. The clock idles low and every byte goes out most significant bit first. The SCK half-period and the minimum chip-select high time between transactions are both set in system clocks by parameters. The erase opcode is a parameter (default 0xC7), so the equivalent 0x60 can be chosen instead. Completion is found without reissuing the read command. Chip-select stays low while the flash repeats its status byte, and the block reads one byte after another until the busy flag clears or a byte budget runs out.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset, cs_n is 1, sck is 0, and busy, done and err are all 0.
- R2: A start pulse while idle sets busy from the next cycle, and the first transaction is the write-enable opcode 0x06 alone in its own chip-select low period.
- R3: The second transaction is the status read opcode 0x05 followed by exactly one status byte. If bit 1 of that byte (write-enable latch) is 0, no erase opcode is sent and the sequence ends with err = 1.
- R4: When the latch bit is 1, the third transaction is the opcode ERASE_OP (default 0xC7) alone in its own chip-select low period.
- R5: Between any two transactions of one sequence, cs_n stays high for at least CS_GAP system clocks.
- R6: After the erase, one chip-select low period carries 0x05 and then status bytes until one has bit 0 (busy) equal to 0. cs_n is then raised and the sequence ends with err = 0.
- R7: If POLL_MAX status bytes in a row all show busy = 1, cs_n is raised after the last of them and the sequence ends with err = 1.
- R8: sck is 0 whenever cs_n is 1. mosi changes only while sck is 0. Each sck high phase lasts CLK_DIV clocks, and bytes are sent MSB first.
- R9: A start pulse while busy is ignored and produces no additional transaction.
- R10: done is a one-cycle pulse, cs_n is 1 while done is 1, busy is 0 from then on, and err holds its value until the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin a chip erase |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| err | output | 1 | Outcome: 1 for latch not set or poll timeout |
| sck | output | 1 | SPI serial clock, idle low |
| cs_n | output | 1 | Flash chip select, active low |
| mosi | output | 1 | Serial data to flash |
| miso | input | 1 | Serial data from flash |

## Verification
The hardest case to reach from the pins is a status poll that ends exactly on its last allowed byte. It must be told apart from one that runs a single byte over. The bench's flash model takes a programmable count of busy status bytes. Directed trials place that count at POLL_MAX minus one and at POLL_MAX, and random trials spread it around that edge. The model can also be told to ignore the write-enable opcode, which steers the sequencer into the path where the latch check fails. A second start pulse is fired partway through every trial to show that it is ignored.

// File: rtl/flash_erase_pkg.sv
// Shared constants and state type for the chip-erase sequencer.
// Assumes a flash whose status byte carries busy at bit 0 and the
// write-enable latch at bit 1.
package flash_erase_pkg;

    localparam logic [7:0] OP_WR_ENABLE = 8'h06;
    localparam logic [7:0] OP_RD_STATUS = 8'h05;
    localparam logic [7:0] OP_FILL      = 8'h00;

    localparam int SR_BUSY_IDX = 0;
    localparam int SR_WEL_IDX  = 1;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WREN,
        ST_GAP_A,
        ST_CHK_CMD,
        ST_CHK_DATA,
        ST_GAP_B,
        ST_ERASE,
        ST_GAP_C,
        ST_POLL_CMD,
        ST_POLL_DATA,
        ST_FIN
    } seq_state_t;

endpackage

// File: rtl/fes_spi_byte.sv
// Mode-0 SPI byte engine. On go it transfers one byte MSB first: SCK
// low for CLK_DIV clocks, high for CLK_DIV clocks, eight times. MISO is
// captured at each rising SCK edge, and MOSI moves only at falling edges
// (or at load, while SCK is low). done pulses one clock after the last
// falling edge, with rx_byte valid.
// Assumes go arrives only while the engine is idle.
module fes_spi_byte #(
    parameter int CLK_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx_byte
);
    localparam int DW = $clog2(CLK_DIV + 1);
    localparam logic [DW-1:0] DIV_LAST = DW'(CLK_DIV - 1);

    logic          active_q;
    logic          sck_q;
    logic [DW-1:0] cnt_q;
    logic [2:0]    bit_q;
    logic [7:0]    sh_q;
    logic [7:0]    rx_q;
    logic          done_q;

    // Phase counter, SCK toggling, shifting and capture of one byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            sck_q    <= 1'b0;
            cnt_q    <= '0;
            bit_q    <= '0;
            sh_q     <= '0;
            rx_q     <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!active_q) begin
                if (go) begin
                    active_q <= 1'b1;
                    sck_q    <= 1'b0;
                    cnt_q    <= '0;
                    bit_q    <= '0;
                    sh_q     <= tx_byte;
                end
            end else if (cnt_q == DIV_LAST) begin
                cnt_q <= '0;
                if (!sck_q) begin
                    sck_q <= 1'b1;
                    rx_q  <= {rx_q[6:0], miso};
                end else begin
                    sck_q <= 1'b0;
                    if (bit_q == 3'd7) begin
                        active_q <= 1'b0;
                        done_q   <= 1'b1;
                    end else begin
                        bit_q <= bit_q + 3'd1;
                        sh_q  <= {sh_q[6:0], 1'b0};
                    end
                end
            end else begin
                cnt_q <= cnt_q + DW'(1);
            end
        end
    end

    assign sck     = sck_q;
    assign mosi    = sh_q[7];
    assign done    = done_q;
    assign rx_byte = rx_q;

    AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_q && $past(sck_q)) |-> $stable(mosi)); // R8
    AST_GO_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !active_q); // R9
    AST_SCK_RESTS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !active_q |-> !sck_q); // R8

endmodule

// File: rtl/fes_gap_timer.sv
// Chip-select high timer. go loads it, and done is high in the clock
// where GAP clocks have elapsed since the load.
// Assumes GAP >= 1.
module fes_gap_timer #(
    parameter int GAP = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic done
);
    localparam int GW = $clog2(GAP + 1);
    localparam logic [GW-1:0] GAP_LAST = GW'(GAP - 1);

    logic          run_q;
    logic [GW-1:0] cnt_q;

    // Count the high interval once per load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (go) begin
            run_q <= 1'b1;
            cnt_q <= '0;
        end else if (run_q) begin
            if (cnt_q == GAP_LAST) begin
                run_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q + GW'(1);
            end
        end
    end

    assign done = run_q && (cnt_q == GAP_LAST);

    AST_GAP_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !run_q); // R5

endmodule

// File: rtl/fes_poll_limit.sv
// Counter of status bytes read in the completion poll. last is high
// while the byte in flight is the final one the budget allows.
// Assumes LIMIT >= 1 and that inc stops once last has been used.
module fes_poll_limit #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int PW = $clog2(LIMIT + 1);
    localparam logic [PW-1:0] LIM_LAST = PW'(LIMIT - 1);

    logic [PW-1:0] cnt_q;

    // Track how many status bytes have completed in this poll.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + PW'(1);
        end
    end

    assign last = (cnt_q == LIM_LAST);

    AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        inc |-> (cnt_q < PW'(LIMIT))); // R7

endmodule

// File: rtl/flash_erase_seq.sv
// Chip-erase sequencer top. Runs write-enable, latch check, erase and
// a busy poll over SPI mode 0, then pulses done with err as the result.
// Assumes a flash that repeats its status byte while chip select stays
// low and that executes an opcode when chip select rises.
module flash_erase_seq #(
    parameter int         CLK_DIV  = 2,
    parameter int         CS_GAP   = 4,
    parameter int         POLL_MAX = 4096,
    parameter logic [7:0] ERASE_OP = 8'hC7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done,
    output logic err,
    output logic sck,
    output logic cs_n,
    output logic mosi,
    input  logic miso
);
    import flash_erase_pkg::*;

    localparam int HW = $clog2(CS_GAP + 2);
    localparam logic [HW-1:0] HI_SAT = HW'(CS_GAP + 1);

    seq_state_t st_q;
    logic       cs_n_q;
    logic       busy_q;
    logic       done_q;
    logic       err_q;
    logic       fail_q;
    logic       wel_ok_q;
    logic       bs_go_q;
    logic [7:0] bs_tx_q;
    logic       gap_go_q;

    logic       bs_done;
    logic [7:0] bs_rx;
    logic       gap_done;
    logic       poll_clr;
    logic       poll_inc;
    logic       poll_last;

    fes_spi_byte #(.CLK_DIV(CLK_DIV)) u_byte (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (bs_go_q),
        .tx_byte (bs_tx_q),
        .miso    (miso),
        .sck     (sck),
        .mosi    (mosi),
        .done    (bs_done),
        .rx_byte (bs_rx)
    );

    fes_gap_timer #(.GAP(CS_GAP)) u_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (gap_go_q),
        .done  (gap_done)
    );

    fes_poll_limit #(.LIMIT(POLL_MAX)) u_poll (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (poll_clr),
        .inc   (poll_inc),
        .last  (poll_last)
    );

    // Poll counter control: cleared as the poll opens, bumped per byte.
    always_comb begin
        poll_clr = (st_q == ST_GAP_C) && gap_done;
        poll_inc = (st_q == ST_POLL_DATA) && bs_done;
    end

    // Main sequence: each transaction, gap and decision in turn.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            cs_n_q   <= 1'b1;
            busy_q   <= 1'b0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
            fail_q   <= 1'b0;
            wel_ok_q <= 1'b0;
            bs_go_q  <= 1'b0;
            bs_tx_q  <= '0;
            gap_go_q <= 1'b0;
        end else begin
            bs_go_q  <= 1'b0;
            gap_go_q <= 1'b0;
            done_q   <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        busy_q   <= 1'b1;
                        err_q    <= 1'b0;
                        fail_q   <= 1'b0;
                        wel_ok_q <= 1'b0;
                        cs_n_q   <= 1'b0;
                        bs_go_q  <= 1'b1;
                        bs_tx_q  <= OP_WR_ENABLE;
                        st_q     <= ST_WREN;
                    end
                end
                ST_WREN: begin
                    if (bs_done) begin
                        cs_n_q   <= 1'b1;
                        gap_go_q <= 1'b1;
                        st_q     <= ST_GAP_A;
                    end
                end
                ST_GAP_A: begin
                    if (gap_done) begin
                        cs_n_q  <= 1'b0;
                        bs_go_q <= 1'b1;
                        bs_tx_q <= OP_RD_STATUS;
                        st_q    <= ST_CHK_CMD;
                    end
                end
                ST_CHK_CMD: begin
                    if (bs_done) begin
                        bs_go_q <= 1'b1;
                        bs_tx_q <= OP_FILL;
                        st_q    <= ST_CHK_DATA;
                    end
                end
                ST_CHK_DATA: begin
                    if (bs_done) begin
                        wel_ok_q <= bs_rx[SR_WEL_IDX];
                        cs_n_q   <= 1'b1;
                        gap_go_q <= 1'b1;
                        st_q     <= ST_GAP_B;
                    end
                end
                ST_GAP_B: begin
                    if (gap_done) begin
                        if (wel_ok_q) begin
                            cs_n_q  <= 1'b0;
                            bs_go_q <= 1'b1;
                            bs_tx_q <= ERASE_OP;
                            st_q    <= ST_ERASE;
                        end else begin
                            fail_q <= 1'b1;
                            st_q   <= ST_FIN;
                        end
                    end
                end
                ST_ERASE: begin
                    if (bs_done) begin
                        cs_n_q   <= 1'b1;
                        gap_go_q <= 1'b1;
                        st_q     <= ST_GAP_C;
                    end
                end
                ST_GAP_C: begin
                    if (gap_done) begin
                        cs_n_q  <= 1'b0;
                        bs_go_q <= 1'b1;
                        bs_tx_q <= OP_RD_STATUS;
                        st_q    <= ST_POLL_CMD;
                    end
                end
                ST_POLL_CMD: begin
                    if (bs_done) begin
                        bs_go_q <= 1'b1;
                        bs_tx_q <= OP_FILL;
                        st_q    <= ST_POLL_DATA;
                    end
                end
                ST_POLL_DATA: begin
                    if (bs_done) begin
                        if (!bs_rx[SR_BUSY_IDX]) begin
                            fail_q <= 1'b0;
                            cs_n_q <= 1'b1;
                            st_q   <= ST_FIN;
                        end else if (poll_last) begin
                            fail_q <= 1'b1;
                            cs_n_q <= 1'b1;
                            st_q   <= ST_FIN;
                        end else begin
                            bs_go_q <= 1'b1;
                            bs_tx_q <= OP_FILL;
                        end
                    end
                end
                ST_FIN: begin
                    done_q <= 1'b1;
                    err_q  <= fail_q;
                    busy_q <= 1'b0;
                    st_q   <= ST_IDLE;
                end
                default: begin
                    st_q <= ST_IDLE;
                end
            endcase
        end
    end

    assign cs_n = cs_n_q;
    assign busy = busy_q;
    assign done = done_q;
    assign err  = err_q;

    // Chip-select high run length, saturating, for the gap check.
    logic [HW-1:0] hi_cnt_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt_q <= '0;
        end else if (!cs_n_q) begin
            hi_cnt_q <= '0;
        end else if (hi_cnt_q != HI_SAT) begin
            hi_cnt_q <= hi_cnt_q + HW'(1);
        end
    end

    AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_DONE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n && !busy)); // R10
    AST_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cs_n) && ($past(st_q) != ST_IDLE)) |-> ($past(hi_cnt_q) >= HW'(CS_GAP - 1))); // R5
    AST_ERASE_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ERASE) |-> wel_ok_q); // R3

endmodule

// File: tb/flash_erase_seq_tb_top.sv
// Bench: behavioural flash model with a programmable busy length and an
// option to ignore write enable, directed corners plus seeded random trials.
module flash_erase_seq_tb_top;

    localparam int CLK_DIV_T  = 2;
    localparam int CS_GAP_T   = 4;
    localparam int POLL_MAX_T = 8;
    localparam logic [7:0] ERASE_T = 8'hC7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic miso = 1'b0;
    logic busy, done, err, sck, cs_n, mosi;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    flash_erase_seq #(
        .CLK_DIV(CLK_DIV_T), .CS_GAP(CS_GAP_T),
        .POLL_MAX(POLL_MAX_T), .ERASE_OP(ERASE_T)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .err(err), .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso)
    );

    // ---------------- flash model ----------------
    int         m_bits;
    logic [7:0] m_cmd;
    logic [7:0] m_sr;
    bit         m_wel;
    bit         m_erasing;
    int         m_busy_left;
    int         m_busy_init;
    bit         m_ignore_wren;
    int         sess_cnt;
    logic [7:0] sess_op [8];
    int         sess_bytes [8];
    int         erase_exec;

    // Session start: reset the bit counter.
    always @(negedge cs_n) m_bits = 0;

    // Capture command bits on rising SCK.
    always @(posedge sck) begin
        if (!cs_n) begin
            if (m_bits < 8) m_cmd = {m_cmd[6:0], mosi};
            m_bits = m_bits + 1;
        end
    end

    // Drive status bits on falling SCK during a status read.
    always @(negedge sck) begin
        if (!cs_n && m_bits >= 8 && m_cmd == 8'h05) begin
            int idx;
            idx = (m_bits - 8) % 8;
            if (idx == 0) begin
                if (m_erasing && m_busy_left == 0) begin
                    m_erasing = 1'b0;
                    m_wel = 1'b0;
                end
                m_sr = {6'b0, m_wel, m_erasing};
                if (m_erasing) m_busy_left = m_busy_left - 1;
            end
            miso = m_sr[7 - idx];
        end
    end

    // Session end: execute the opcode and log it.
    always @(posedge cs_n) begin
        if (m_bits == 8) begin
            if (m_cmd == 8'h06 && !m_ignore_wren) m_wel = 1'b1;
            if (m_cmd == ERASE_T && m_wel) begin
                m_erasing = 1'b1;
                m_busy_left = m_busy_init;
                erase_exec = erase_exec + 1;
            end
        end
        if (sess_cnt < 8) begin
            sess_op[sess_cnt] = m_cmd;
            sess_bytes[sess_cnt] = (m_bits >= 8) ? (m_bits - 8) / 8 : 0;
        end
        sess_cnt = sess_cnt + 1;
    end

    // ---------------- pin monitors ----------------
    int  hi_cs_run = 0;
    int  hi_sck_run = 0;
    logic prev_cs = 1'b1, prev_sck = 1'b0, prev_mosi = 1'b0;
    int  gap_viol = 0;
    int  mode_viol = 0;

    // Sample pins mid-cycle for gap and mode-0 rules, plus the watchdog.
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rst_n) begin
            if (cs_n && sck) mode_viol = mode_viol + 1;
            if (prev_sck && sck && mosi !== prev_mosi) mode_viol = mode_viol + 1;
            if (sck) hi_sck_run = hi_sck_run + 1;
            else begin
                if (prev_sck && hi_sck_run != CLK_DIV_T) mode_viol = mode_viol + 1;
                hi_sck_run = 0;
            end
            if (cs_n) hi_cs_run = hi_cs_run + 1;
            else begin
                if (prev_cs && sess_cnt > 0 && hi_cs_run < CS_GAP_T) gap_viol = gap_viol + 1;
                hi_cs_run = 0;
            end
            prev_cs = cs_n;
            prev_sck = sck;
            prev_mosi = mosi;
        end
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // ---------------- checking helpers ----------------
    task automatic check_eq(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit exp_err(input int n, input bit ign);
        if (ign) return 1'b1;
        return (n + 1 > POLL_MAX_T);
    endfunction

    function automatic int exp_poll_bytes(input int n);
        return (n + 1 < POLL_MAX_T) ? n + 1 : POLL_MAX_T;
    endfunction

    task automatic run_trial(input int n, input bit ign);
        int waited;
        bit got;
        m_busy_init = n;
        m_ignore_wren = ign;
        m_wel = 1'b0;
        m_erasing = 1'b0;
        m_busy_left = 0;
        sess_cnt = 0;
        erase_exec = 0;
        gap_viol = 0;
        mode_viol = 0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check_eq("R2 busy after start", int'(busy), 1);
        repeat (40) @(negedge clk);
        start = 1'b1;                       // R9: stray start while busy
        @(negedge clk);
        start = 1'b0;
        got = 1'b0;
        waited = 0;
        while (!got && waited < 5000) begin
            @(negedge clk);
            waited = waited + 1;
            if (done) got = 1'b1;
        end
        check_eq("R10 done seen", int'(got), 1);
        if (got) begin
            check_eq("R10 cs_n high at done", int'(cs_n), 1);
            check_eq("R10 busy low at done", int'(busy), 0);
            check_eq(ign ? "R3 err on clear latch" :
                     (exp_err(n, ign) ? "R7 err on timeout" : "R6 err clear"),
                     int'(err), int'(exp_err(n, ign)));
            @(negedge clk);
            check_eq("R10 done single cycle", int'(done), 0);
        end
        repeat (20) @(negedge clk);
        check_eq("R10 err held", int'(err), int'(exp_err(n, ign)));
        check_eq("R2 first opcode write enable", int'(sess_op[0]), 8'h06);
        check_eq("R2 write enable alone", sess_bytes[0], 0);
        check_eq("R3 status opcode", int'(sess_op[1]), 8'h05);
        check_eq("R3 one status byte", sess_bytes[1], 1);
        if (ign) begin
            check_eq("R3 no erase session", sess_cnt, 2);
            check_eq("R3 no erase executed", erase_exec, 0);
        end else begin
            check_eq("R9 session count", sess_cnt, 4);
            check_eq("R4 erase opcode", int'(sess_op[2]), int'(ERASE_T));
            check_eq("R4 erase executed once", erase_exec, 1);
            check_eq("R6 poll opcode", int'(sess_op[3]), 8'h05);
            check_eq(exp_err(n, ign) ? "R7 poll bytes" : "R6 poll bytes",
                     sess_bytes[3], exp_poll_bytes(n));
        end
        check_eq("R5 gap violations", gap_viol, 0);
        check_eq("R8 mode violations", mode_viol, 0);
        check_eq("R9 idle after done", int'(busy), 0);
    endtask

    initial begin
        int seed_v;
        seed_v = $urandom(32'h5eed_0123);
        m_busy_init = 0;
        m_ignore_wren = 1'b0;
        m_wel = 1'b0;
        m_erasing = 1'b0;
        m_busy_left = 0;
        sess_cnt = 0;
        erase_exec = 0;
        m_cmd = 8'h00;
        m_sr = 8'h00;
        m_bits = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1 cs_n", int'(cs_n), 1);
        check_eq("R1 sck", int'(sck), 0);
        check_eq("R1 busy", int'(busy), 0);
        check_eq("R1 done", int'(done), 0);
        check_eq("R1 err", int'(err), 0);
        // Directed corners.
        run_trial(0, 1'b0);
        run_trial(POLL_MAX_T - 1, 1'b0);
        run_trial(POLL_MAX_T, 1'b0);
        run_trial(3, 1'b1);
        run_trial(POLL_MAX_T + 2, 1'b0);
        // Seeded random trials.
        for (int t = 0; t < 20; t++) begin
            int n;
            bit ign;
            n = int'($urandom % (POLL_MAX_T + 3));
            ign = (($urandom % 5) == 0);
            run_trial(n, ign);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule